// File: doc/BRIEF.md
# Single-Word SPI Master Engine

This block is a serial peripheral master that moves one word per request. A start pulse samples a 16-bit transmit word and the current configuration. The block then pulls its active-low chip select down, waits a programmable lead time and runs the serial clock. While the clock runs it shifts the word out most-significant bit first and captures the same number of bits from the data-in line. After a programmable trail time it raises chip select again, presents the received word and pulses done for one cycle.

The configuration inputs set five things: the word length through a 4-bit size code, the idle level of the serial clock, the clock phase, a divider that gives the length of each clock half-period in system cycles, and the two delays. A divider of zero turns the engine off, so start requests are dropped silently. An illegal divider of one, or a reserved size code, rejects the request and raises a one-cycle error pulse.

Top module: `spi_xfer_engine`

## Requirements
- R1: Size code 0 selects 16 bits and codes 8 to 15 select that many bits. The outgoing bits are tx_word[n-1] down to tx_word[0], one per clock period, most significant first.
- R2: The received word holds the n captured bits right-aligned, first received bit at position n-1, and bits 15 down to n read zero.
- R3: While chip select is high, the serial clock rests at the level of cfg_cpol (0 low, 1 high), and it is back at that level when the transfer ends.
- R4: With cfg_cpha=0, the first data bit is on mosi in the cycle chip select falls. Input is captured on leading clock edges and mosi changes only on trailing edges.
- R5: With cfg_cpha=1, mosi changes on leading edges and input is captured on trailing edges.
- R6: Every half-period of the serial clock lasts cfg_baud system cycles.
- R7: The first serial clock edge comes cfg_pre_dly+1+cfg_baud cycles after the clock edge that accepts start.
- R8: Done is high for exactly one cycle, cfg_pre_dly+cfg_post_dly+2+2·n·cfg_baud cycles after the accepting edge. Chip select goes high in that same cycle.
- R9: With cfg_baud=0, a start request causes no transfer, no error pulse and no chip-select activity.
- R10: A start with cfg_baud=1 or a size code of 1 to 7 starts no transfer. Instead err is high for exactly the one cycle after the request.
- R11: A start request while busy is ignored. The running transfer keeps its timing and data, and no second transfer follows.
- R12: Exactly 2·n serial clock edges occur per transfer, all while chip select is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_size | input | 4 | Word length code |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | Clock phase select |
| cfg_baud | input | 8 | Half-period length in system cycles, 0 = off |
| cfg_pre_dly | input | 8 | Chip-select-to-clock delay, count+1 cycles |
| cfg_post_dly | input | 8 | Delay after the last clock edge, count+1 cycles |
| start | input | 1 | Transfer request pulse |
| tx_word | input | 16 | Word to send, sampled with start |
| miso | input | 1 | Serial data from the peripheral |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the peripheral |
| cs_n | output | 1 | Chip select, active low |
| rx_word | output | 16 | Received word, valid from done |
| done | output | 1 | One-cycle end-of-transfer pulse |
| err | output | 1 | One-cycle rejected-request pulse |
| busy | output | 1 | Transfer in progress |

## Verification
Two functions can fall in the same cycle: a new start request and an ongoing transfer, where the request decoder and the transfer controller both react to the same edge. The bench provokes this by pulsing start with a different word and a different configuration three cycles into a transfer. It judges the result by the done cycle count, by the bits seen on mosi and in rx_word, and by chip select staying high afterwards. Reject and disable requests are judged at err, cs_n and busy in the cycles right after the request.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LEAD,
    ST_SHIFT,
    ST_TRAIL
  } xfer_state_e;

  // 0 -> 16 bits, 8..15 -> same count, 1..7 reserved
  function automatic logic size_code_ok(input logic [3:0] code);
    return (code == 4'd0) || code[3];
  endfunction

  function automatic logic [4:0] size_code_bits(input logic [3:0] code);
    return (code == 4'd0) ? 5'd16 : {1'b0, code};
  endfunction

endpackage

// File: rtl/spi_half_timer.sv
module spi_half_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         run,
  input  logic [W-1:0] period,
  output logic         tick
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= period - 1'b1;
    end else if (run) begin
      cnt_q <= (cnt_q == '0) ? period - 1'b1 : cnt_q - 1'b1;
    end
  end

  assign tick = run && (cnt_q == '0);
endmodule

// File: rtl/spi_dly_timer.sv
module spi_dly_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] value,
  output logic         expired
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= value;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/spi_shift_unit.sv
module spi_shift_unit #(
  parameter int DATA_W = 16,
  localparam int BIT_W = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              load_cpha,
  input  logic [BIT_W-1:0]  load_bits,
  input  logic [DATA_W-1:0] load_word,
  input  logic              launch,
  input  logic              capture,
  input  logic              miso,
  output logic              mosi,
  output logic [DATA_W-1:0] rx_word
);
  logic [DATA_W-1:0] tx_sr_q;
  logic [DATA_W-1:0] rx_sr_q;
  logic              mosi_q;
  logic [DATA_W-1:0] aligned;

  // move bit n-1 of the word to the top of the shifter
  assign aligned = load_word << (BIT_W'(DATA_W) - load_bits);

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_sr_q <= '0;
      rx_sr_q <= '0;
      mosi_q  <= 1'b0;
    end else if (load) begin
      rx_sr_q <= '0;
      if (!load_cpha) begin
        mosi_q  <= aligned[DATA_W-1];
        tx_sr_q <= aligned << 1;
      end else begin
        mosi_q  <= 1'b0;
        tx_sr_q <= aligned;
      end
    end else begin
      if (launch) begin
        mosi_q  <= tx_sr_q[DATA_W-1];
        tx_sr_q <= tx_sr_q << 1;
      end
      if (capture) begin
        rx_sr_q <= {rx_sr_q[DATA_W-2:0], miso};
      end
    end
  end

  assign mosi    = mosi_q;
  assign rx_word = rx_sr_q;
endmodule

// File: rtl/spi_xfer_engine.sv
module spi_xfer_engine
  import spi_xfer_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BAUD_W = 8,
  parameter int DLY_W  = 8,
  parameter int SIZE_W = 4,
  localparam int BIT_W  = $clog2(DATA_W + 1),
  localparam int EDGE_W = $clog2(2 * DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SIZE_W-1:0] cfg_size,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic [BAUD_W-1:0] cfg_baud,
  input  logic [DLY_W-1:0]  cfg_pre_dly,
  input  logic [DLY_W-1:0]  cfg_post_dly,
  input  logic              start,
  input  logic [DATA_W-1:0] tx_word,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic              cs_n,
  output logic [DATA_W-1:0] rx_word,
  output logic              done,
  output logic              err,
  output logic              busy
);
  xfer_state_e       state_q;
  logic              cs_n_q, sclk_q, cpol_q, cpha_q, done_q, err_q;
  logic [BIT_W-1:0]  nbits_q;
  logic [BAUD_W-1:0] baud_q;
  logic [DLY_W-1:0]  post_q;
  logic [EDGE_W-1:0] edge_q;
  logic [DATA_W-1:0] rx_q;
  logic [DATA_W-1:0] rx_sr;
  logic [BIT_W-1:0]  req_bits;

  logic req, cfg_ok, accept, reject;
  logic dly_load, dly_exp;
  logic [DLY_W-1:0] dly_val;
  logic half_load, half_run, tick;
  logic leading, capture, launch, last_edge;

  assign req      = (state_q == ST_IDLE) && start && (cfg_baud != '0);
  assign cfg_ok   = size_code_ok(cfg_size) && (cfg_baud != BAUD_W'(1));
  assign accept   = req && cfg_ok;
  assign reject   = req && !cfg_ok;
  assign req_bits = BIT_W'(size_code_bits(cfg_size));

  assign leading   = (sclk_q == cpol_q);
  assign capture   = tick && (leading != cpha_q);
  assign launch    = tick && (leading == cpha_q);
  assign last_edge = (edge_q == EDGE_W'({nbits_q, 1'b0} - 1'b1));

  assign dly_load  = accept || ((state_q == ST_SHIFT) && tick && last_edge);
  assign dly_val   = accept ? cfg_pre_dly : post_q;
  assign half_load = (state_q == ST_LEAD) && dly_exp;
  assign half_run  = (state_q == ST_SHIFT);

  spi_dly_timer #(.W(DLY_W)) dly_i (
    .clk(clk), .rst(rst), .load(dly_load), .value(dly_val), .expired(dly_exp)
  );

  spi_half_timer #(.W(BAUD_W)) half_i (
    .clk(clk), .rst(rst), .load(half_load), .run(half_run),
    .period(baud_q), .tick(tick)
  );

  spi_shift_unit #(.DATA_W(DATA_W)) shift_i (
    .clk(clk), .rst(rst), .load(accept), .load_cpha(cfg_cpha),
    .load_bits(req_bits), .load_word(tx_word), .launch(launch),
    .capture(capture), .miso(miso), .mosi(mosi), .rx_word(rx_sr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cs_n_q  <= 1'b1;
      sclk_q  <= 1'b0;
      cpol_q  <= 1'b0;
      cpha_q  <= 1'b0;
      nbits_q <= '0;
      baud_q  <= '0;
      post_q  <= '0;
      edge_q  <= '0;
      rx_q    <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= reject;
      unique case (state_q)
        ST_IDLE: begin
          sclk_q <= cfg_cpol;
          if (accept) begin
            state_q <= ST_LEAD;
            cs_n_q  <= 1'b0;
            cpol_q  <= cfg_cpol;
            cpha_q  <= cfg_cpha;
            nbits_q <= req_bits;
            baud_q  <= cfg_baud;
            post_q  <= cfg_post_dly;
          end
        end
        ST_LEAD: begin
          if (dly_exp) begin
            state_q <= ST_SHIFT;
            edge_q  <= '0;
          end
        end
        ST_SHIFT: begin
          if (tick) begin
            sclk_q <= ~sclk_q;
            edge_q <= edge_q + 1'b1;
            if (last_edge) state_q <= ST_TRAIL;
          end
        end
        ST_TRAIL: begin
          if (dly_exp) begin
            state_q <= ST_IDLE;
            cs_n_q  <= 1'b1;
            done_q  <= 1'b1;
            rx_q    <= rx_sr;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign sclk    = sclk_q;
  assign cs_n    = cs_n_q;
  assign rx_word = rx_q;
  assign done    = done_q;
  assign err     = err_q;
  assign busy    = (state_q != ST_IDLE);
endmodule

// File: rtl/spi_xfer_chk.sv
module spi_xfer_chk #(
  parameter int BAUD_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              busy,
  input logic [BAUD_W-1:0] cfg_baud,
  input logic              cfg_cpol,
  input logic              cs_n,
  input logic              sclk,
  input logic              mosi,
  input logic              done,
  input logic              err,
  input logic              cpol_q,
  input logic              cpha_q
);
  // R3
  sclk_idle_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && cs_n && $past(cs_n)) |-> (sclk == $past(cfg_cpol)));

  // R4 R5
  mosi_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && $past(!cs_n) && (sclk != $past(sclk)) &&
     (($past(sclk) == cpol_q) != cpha_q)) |-> $stable(mosi));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8
  done_cs_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (cs_n && $past(!cs_n)));

  // R9
  baud_off_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && (cfg_baud == '0)) |=> (cs_n && !err));

  // R10
  baud_one_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && (cfg_baud == BAUD_W'(1))) |=> (err && cs_n));

  // R10
  err_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    err |=> !err);

  // R12
  sclk_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && cs_n && $past(cs_n) && $stable(cfg_cpol) && $past($stable(cfg_cpol)))
      |-> $stable(sclk));
endmodule

bind spi_xfer_engine spi_xfer_chk #(.BAUD_W(BAUD_W)) chk_i (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .cfg_baud(cfg_baud),
  .cfg_cpol(cfg_cpol), .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .done(done),
  .err(err), .cpol_q(cpol_q), .cpha_q(cpha_q)
);

// File: tb/spi_xfer_engine_tb_top.sv
module spi_xfer_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  cfg_size = 4'd8;
  logic        cfg_cpol = 1'b0;
  logic        cfg_cpha = 1'b0;
  logic [7:0]  cfg_baud = 8'd2;
  logic [7:0]  cfg_pre_dly = 8'd0;
  logic [7:0]  cfg_post_dly = 8'd0;
  logic        start = 1'b0;
  logic [15:0] tx_word = 16'h0;
  logic        miso = 1'b0;
  logic        sclk, mosi, cs_n, done, err, busy;
  logic [15:0] rx_word;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  spi_xfer_engine dut_i (
    .clk(clk), .rst(rst), .cfg_size(cfg_size), .cfg_cpol(cfg_cpol),
    .cfg_cpha(cfg_cpha), .cfg_baud(cfg_baud), .cfg_pre_dly(cfg_pre_dly),
    .cfg_post_dly(cfg_post_dly), .start(start), .tx_word(tx_word),
    .miso(miso), .sclk(sclk), .mosi(mosi), .cs_n(cs_n), .rx_word(rx_word),
    .done(done), .err(err), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(cs_n == 1'b1 && done == 1'b0 && err == 1'b0 && busy == 1'b0,
        "R8 reset outputs", {cs_n, done, err, busy}, 4'b1000);
    chk(sclk == cfg_cpol, "R3 idle level after reset", sclk, cfg_cpol);
  endtask

  // one transfer with a bench-side peripheral model
  task automatic t_xfer(input logic [3:0] sz, input logic pol, input logic pha,
                        input logic [7:0] bd, input logic [7:0] pr, input logic [7:0] po,
                        input logic [15:0] tx, input logic [15:0] pat, input bit poke);
    int n, cyc, edges, first_e, second_e, bidx;
    logic [15:0] mask, got;
    logic prev_sclk;
    bit leading_e, cap;
    string ph;
    n = (sz == 4'd0) ? 16 : int'(sz);
    mask = (n == 16) ? 16'hFFFF : ((16'h1 << n) - 16'h1);
    ph = pha ? "R5" : "R4";
    @(negedge clk);
    cfg_size = sz; cfg_cpol = pol; cfg_cpha = pha; cfg_baud = bd;
    cfg_pre_dly = pr; cfg_post_dly = po;
    @(negedge clk);
    chk(sclk == pol, "R3 idle level before start", sclk, pol);
    start = 1'b1; tx_word = tx;
    @(posedge clk);
    #1 start = 1'b0;
    chk(cs_n == 1'b0, "R7 chip select low after start", cs_n, 0);
    if (!pha) begin
      chk(mosi == tx[n-1], "R4 first bit before first edge", mosi, tx[n-1]);
      miso = pat[n-1];
    end
    cyc = 0; edges = 0; first_e = -1; second_e = -1; got = '0;
    prev_sclk = sclk;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      #1 cyc++;
      if (poke && cyc == 3) begin
        start = 1'b1; tx_word = ~tx; cfg_size = 4'd0; cfg_baud = 8'd5;
      end
      if (poke && cyc == 4) start = 1'b0;
      if (sclk != prev_sclk) begin
        edges++;
        if (edges == 1) first_e = cyc;
        if (edges == 2) second_e = cyc;
        if (cs_n) chk(0, "R12 edge with chip select high", edges, 0);
        leading_e = (prev_sclk == pol);
        cap = (leading_e != pha);
        if (cap) begin
          got = {got[14:0], mosi};
        end else begin
          bidx = pha ? (edges - 1) / 2 : edges / 2;
          if (bidx < n) miso = pat[n-1-bidx];
        end
        prev_sclk = sclk;
      end
    end
    chk(done == 1'b1 && cs_n == 1'b1, "R8 done with chip select high", {done, cs_n}, 2'b11);
    chk(cyc == pr + po + 2 + 2 * n * bd, poke ? "R11 timing with busy start" : "R8 done cycle",
        cyc, pr + po + 2 + 2 * n * bd);
    chk(edges == 2 * n, "R12 edge count", edges, 2 * n);
    chk(first_e == pr + 1 + bd, "R7 lead delay", first_e, pr + 1 + bd);
    chk(second_e - first_e == bd, "R6 half period", second_e - first_e, bd);
    chk(got == (tx & mask), {"R1 ", ph, " transmitted bits"}, got, tx & mask);
    chk(rx_word == (pat & mask), {"R2 ", ph, " received word"}, rx_word, pat & mask);
    chk(sclk == pol, "R3 level after transfer", sclk, pol);
    @(posedge clk);
    #1 chk(done == 1'b0, "R8 done width", done, 0);
    repeat (4) begin
      @(posedge clk);
      #1 chk(cs_n == 1'b1 && busy == 1'b0, poke ? "R11 no second transfer" : "R12 stays idle",
             {cs_n, busy}, 2'b10);
    end
  endtask

  // rejected or disabled request; expect_err selects R10 or R9
  task automatic t_refuse(input logic [3:0] sz, input logic [7:0] bd, input bit expect_err);
    string rq;
    rq = expect_err ? "R10" : "R9";
    @(negedge clk);
    cfg_size = sz; cfg_baud = bd; start = 1'b1; tx_word = 16'hBEEF;
    @(posedge clk);
    #1 start = 1'b0;
    chk(err == expect_err, {rq, " error pulse"}, err, expect_err);
    chk(cs_n == 1'b1 && busy == 1'b0, {rq, " no transfer"}, {cs_n, busy}, 2'b10);
    @(posedge clk);
    #1 chk(err == 1'b0, {rq, " error width"}, err, 0);
    repeat (3) begin
      @(posedge clk);
      #1 chk(cs_n == 1'b1 && done == 1'b0, {rq, " stays idle"}, {cs_n, done}, 2'b10);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_xfer(4'd8,  1'b0, 1'b0, 8'd2, 8'd0, 8'd0, 16'hA5C3, 16'h005A, 1'b0);
    t_xfer(4'd0,  1'b1, 1'b1, 8'd3, 8'd2, 8'd1, 16'hC3A5, 16'h6E91, 1'b0);
    t_xfer(4'd11, 1'b0, 1'b1, 8'd2, 8'd5, 8'd3, 16'hFFFF, 16'hF35B, 1'b0);
    t_xfer(4'd9,  1'b1, 1'b0, 8'd4, 8'd1, 8'd0, 16'h0155, 16'hFEB3, 1'b0);
    t_xfer(4'd15, 1'b0, 1'b0, 8'd2, 8'd0, 8'd2, 16'h4321, 16'h1ACE, 1'b1);
    t_refuse(4'd5, 8'd2, 1'b1);
    t_refuse(4'd8, 8'd1, 1'b1);
    t_refuse(4'd8, 8'd0, 1'b0);
    t_xfer(4'd12, 1'b1, 1'b1, 8'd2, 8'd0, 8'd0, 16'h0ABC, 16'h0777, 1'b0);
    finished = 1'b1;
    summary();
    $finish;
  end
endmodule